// File: doc/BRIEF.md
# Console Test-Mode Sequencer

This block drives the processor from the front panel while the operator has the machine in test mode. Each operation comes from an 18-bit switch register, the instruction switches, and not from memory. A second 18-bit switch register, the data switches, supplies the value to deposit. Each press of the step button runs exactly one operation. The block decodes the two most significant instruction-switch bits as a console command. It can deposit the data switches into memory, add a memory word into the accumulator while showing that word in the memory buffer, leave test mode and start the program at an address, or hand the low field to the core's operate unit once.

While test mode is active or an operation is still running, the block holds the core. The hold stops the core's own fetch and gives the block the memory port and the write ports of the accumulator, memory buffer and program counter. The operate step is not executed here. It is requested from the core's operate logic, and the block waits for that logic to report completion. The step button and the mode switch are asynchronous. They pass through synchronisers, and only the rising edges count.

Top module: `tcm_console`

## Requirements
- R1: After reset the block is out of test mode, does not hold the core, and drives no memory request, register write, operate request or run pulse.
- R2: A rising edge of the synchronised mode switch enters test mode. The core-hold output is high whenever test mode is active or an operation is in progress, and it is high for every cycle in which a memory request is driven.
- R3: Command code 00 in instruction-switch bits [17:16] writes the data switches to the address in instruction-switch bits [15:0].
- R4: Command code 01 reads the address in bits [15:0]. When the acknowledge arrives, the memory buffer is loaded with the read word. In the same cycle the accumulator is loaded with the ones'-complement sum of its old value and that word, where the carry out of bit 17 is added back into bit 0.
- R5: Command code 10 loads the program counter with bits [15:0] and raises the run pulse for exactly one cycle, in the same cycle as that load. Test mode and the core hold are released on the next cycle.
- R6: Command code 11 raises the operate request with bits [15:0] as its field. Both stay unchanged until the operate unit signals completion.
- R7: A step press is ignored while an operation is in progress and while the block is out of test mode.
- R8: One rising edge of the step input starts exactly one operation, however long the button stays pressed.
- R9: A memory request keeps its address, direction and write data unchanged until it is acknowledged.
- R10: Both switch registers are sampled on the accepted step edge. Changing them during the operation does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sw | input | 1 | Test-mode switch, asynchronous |
| step_btn | input | 1 | Step button, asynchronous |
| instr_sw | input | 18 | Instruction switches: command in [17:16], field in [15:0] |
| data_sw | input | 18 | Data switches used by the deposit command |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 18 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 18 | Memory read data |
| acc_in | input | 18 | Current accumulator value from the core |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 18 | New accumulator value |
| mbuf_we | output | 1 | Memory-buffer write strobe |
| mbuf_wdata | output | 18 | New memory-buffer value |
| pc_we | output | 1 | Program-counter write strobe |
| pc_wdata | output | 16 | New program-counter value |
| run_start | output | 1 | One-cycle pulse that starts normal execution |
| oper_req | output | 1 | Request to the core's operate unit |
| oper_field | output | 16 | Operate field passed with the request |
| oper_done | input | 1 | Operate unit completion |
| test_mode | output | 1 | Test mode active |
| busy | output | 1 | Operation in progress |
| core_hold | output | 1 | Core fetch inhibited and register/memory ports granted |

## Verification
Some rules are checked by the assertions on every cycle. Memory requests stay stable until acknowledged, and a memory request is never driven without the core hold. An accumulator write always comes with a memory-buffer write of the acknowledged word. The operate request is held with a stable field until completion. The run pulse lasts one cycle and is followed by leaving test mode. Some properties only the bench scenarios can show, by predicting every memory write, accumulator update, program-counter load and operate request in a queue. These are the decoded command values, the end-around carry of the add, the switch sampling at the step edge, and the rule that presses while busy, while held, or outside test mode cause no event at all.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int WORD_W = 18;
  localparam int ADDR_W = WORD_W - 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    CMD_DEPOSIT = 2'b00,
    CMD_ADD     = 2'b01,
    CMD_RUN     = 2'b10,
    CMD_OPER    = 2'b11
  } con_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STORE,
    ST_FETCH,
    ST_RUN,
    ST_OPER
  } con_state_e;

  // ones'-complement sum: carry out of the top bit wraps into bit 0
  function automatic word_t oc_add(word_t a, word_t b);
    logic [WORD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[WORD_W-1:0] + word_t'(s[WORD_W]);
  endfunction

  function automatic con_cmd_e cmd_of(word_t w);
    return con_cmd_e'(w[WORD_W-1 -: 2]);
  endfunction

  function automatic addr_t field_of(word_t w);
    return w[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/tcm_sync.sv
module tcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  localparam int CHAIN = STAGES + 1;
  logic [CHAIN-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh[0] <= 1'b0;
    else        sh[0] <= din;
  end

  for (genvar g = 1; g < CHAIN; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) sh[g] <= 1'b0;
      else        sh[g] <= sh[g-1];
    end
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tcm_seq.sv
module tcm_seq
  import tcm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_rise,
  input  logic  step_rise,
  input  word_t instr_sw,
  input  word_t data_sw,
  output logic  mem_req,
  output logic  mem_we,
  output addr_t mem_addr,
  output word_t mem_wdata,
  input  logic  mem_ack,
  input  word_t mem_rdata,
  input  word_t acc_in,
  output logic  acc_we,
  output word_t acc_wdata,
  output logic  mbuf_we,
  output word_t mbuf_wdata,
  output logic  pc_we,
  output addr_t pc_wdata,
  output logic  run_start,
  output logic  oper_req,
  output addr_t oper_field,
  input  logic  oper_done,
  output logic  test_mode,
  output logic  busy
);
  con_state_e state_q, state_d;
  logic       test_q;
  word_t      instr_q, data_q;

  // named events
  logic accept_ev;
  logic finish_ev;
  logic leave_ev;

  assign accept_ev = step_rise && test_q && (state_q == ST_IDLE);
  assign leave_ev  = (state_q == ST_RUN);

  always_comb begin
    state_d   = state_q;
    finish_ev = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept_ev) begin
        unique case (cmd_of(instr_sw))
          CMD_DEPOSIT: state_d = ST_STORE;
          CMD_ADD:     state_d = ST_FETCH;
          CMD_RUN:     state_d = ST_RUN;
          CMD_OPER:    state_d = ST_OPER;
        endcase
      end
      ST_STORE, ST_FETCH: if (mem_ack) begin
        state_d   = ST_IDLE;
        finish_ev = 1'b1;
      end
      ST_RUN: begin
        state_d   = ST_IDLE;
        finish_ev = 1'b1;
      end
      ST_OPER: if (oper_done) begin
        state_d   = ST_IDLE;
        finish_ev = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      test_q  <= 1'b0;
      instr_q <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (leave_ev)       test_q <= 1'b0;
      else if (mode_rise) test_q <= 1'b1;
      if (accept_ev) begin
        instr_q <= instr_sw;
        data_q  <= data_sw;
      end
    end
  end

  assign mem_req    = (state_q == ST_STORE) || (state_q == ST_FETCH);
  assign mem_we     = (state_q == ST_STORE);
  assign mem_addr   = field_of(instr_q);
  assign mem_wdata  = data_q;
  assign mbuf_we    = (state_q == ST_FETCH) && mem_ack;
  assign mbuf_wdata = mem_rdata;
  assign acc_we     = mbuf_we;
  assign acc_wdata  = oc_add(acc_in, mem_rdata);
  assign pc_we      = leave_ev;
  assign pc_wdata   = field_of(instr_q);
  assign run_start  = leave_ev;
  assign oper_req   = (state_q == ST_OPER);
  assign oper_field = field_of(instr_q);
  assign test_mode  = test_q;
  assign busy       = (state_q != ST_IDLE);

  a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r4_acc_with_mbuf: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> (mbuf_we && mem_ack && !mem_we && mbuf_wdata == mem_rdata));

  a_r5_run_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (!run_start && !test_mode && !busy));

  a_r6_oper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (oper_req && !oper_done) |=> (oper_req && $stable(oper_field)));

  a_r7_idle_outside_test: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !busy) |=> !busy);
endmodule

// File: rtl/tcm_console.sv
module tcm_console
  import tcm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sw,
  input  logic              step_btn,
  input  logic [WORD_W-1:0] instr_sw,
  input  logic [WORD_W-1:0] data_sw,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] acc_in,
  output logic              acc_we,
  output logic [WORD_W-1:0] acc_wdata,
  output logic              mbuf_we,
  output logic [WORD_W-1:0] mbuf_wdata,
  output logic              pc_we,
  output logic [ADDR_W-1:0] pc_wdata,
  output logic              run_start,
  output logic              oper_req,
  output logic [ADDR_W-1:0] oper_field,
  input  logic              oper_done,
  output logic              test_mode,
  output logic              busy,
  output logic              core_hold
);
  logic mode_level, mode_rise;
  logic step_level, step_rise;

  tcm_sync #(.STAGES(SYNC_STAGES)) i_mode_sync (
    .clk(clk), .rst_n(rst_n), .din(mode_sw), .level(mode_level), .rise(mode_rise)
  );

  tcm_sync #(.STAGES(SYNC_STAGES)) i_step_sync (
    .clk(clk), .rst_n(rst_n), .din(step_btn), .level(step_level), .rise(step_rise)
  );

  tcm_seq i_seq (
    .clk(clk), .rst_n(rst_n),
    .mode_rise(mode_rise), .step_rise(step_rise),
    .instr_sw(instr_sw), .data_sw(data_sw),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .acc_in(acc_in), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .mbuf_we(mbuf_we), .mbuf_wdata(mbuf_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .run_start(run_start),
    .oper_req(oper_req), .oper_field(oper_field), .oper_done(oper_done),
    .test_mode(test_mode), .busy(busy)
  );

  assign core_hold = test_mode | busy;

  a_r2_port_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || acc_we || oper_req) |-> core_hold);

  a_r8_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (step_level && !step_rise) |=> !$rose(busy));

  a_r2_enter_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rise && !run_start) |=> test_mode);
endmodule

// File: tb/test_tcm_console.sv
module test_tcm_console;
  import tcm_pkg::*;

  localparam int MEM_LAT = 3;

  typedef enum int {K_WR, K_ADD, K_RUN, K_OPR} kind_e;
  typedef struct {
    kind_e kind;
    int    addr;
    int    data;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_sw = 1'b0, step_btn = 1'b0;
  logic [17:0] instr_sw = '0, data_sw = '0;
  logic mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, pc_wdata, oper_field;
  logic [17:0] mem_wdata, mem_rdata, acc_wdata, mbuf_wdata;
  logic acc_we, mbuf_we, pc_we, run_start, oper_req, oper_done;
  logic test_mode, busy, core_hold;
  logic [17:0] acc_q;
  logic [15:0] pc_q;
  logic [17:0] mem [0:63];
  int mcnt, ocnt, oper_lat;

  int checks = 0, errors = 0;
  bit done_flag = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  tcm_console i_tcm_console (
    .clk(clk), .rst_n(rst_n), .mode_sw(mode_sw), .step_btn(step_btn),
    .instr_sw(instr_sw), .data_sw(data_sw),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .acc_in(acc_q), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .mbuf_we(mbuf_we), .mbuf_wdata(mbuf_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .run_start(run_start),
    .oper_req(oper_req), .oper_field(oper_field), .oper_done(oper_done),
    .test_mode(test_mode), .busy(busy), .core_hold(core_hold)
  );

  function automatic logic [17:0] init_word(int i);
    if (i == 3) return 18'o777776;
    return 18'(i * 18'o1001);
  endfunction

  // bench's own ones'-complement add
  function automatic logic [17:0] bench_add(logic [17:0] a, logic [17:0] b);
    int unsigned t;
    t = int'(a) + int'(b);
    if (t > 32'h3FFFF) t = t - 32'h3FFFF;
    return t[17:0];
  endfunction

  // memory, operate unit and core register models
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; mcnt <= 0;
      oper_done <= 1'b0; ocnt <= 0;
      acc_q <= 18'o5; pc_q <= '0;
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (mcnt == MEM_LAT) begin
          mem_ack <= 1'b1; mcnt <= 0;
          if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
          else        mem_rdata <= mem[mem_addr[5:0]];
        end else mcnt <= mcnt + 1;
      end
      oper_done <= 1'b0;
      if (oper_req && !oper_done) begin
        if (ocnt == oper_lat) begin oper_done <= 1'b1; ocnt <= 0; end
        else ocnt <= ocnt + 1;
      end
      if (acc_we) acc_q <= acc_wdata;
      if (pc_we)  pc_q <= pc_wdata;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0o expected %0o", req, what, act, exp);
    end
  endtask

  // monitor: pops expected events as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we && mem_ack) pop_cmp(K_WR, int'(mem_addr), int'(mem_wdata), "R3");
      if (acc_we) begin
        pop_cmp(K_ADD, int'(mem_addr), int'(acc_wdata), "R4");
        check(mbuf_we && mbuf_wdata == mem_rdata, "R4", "buffer shows word", int'(mbuf_wdata), int'(mem_rdata));
      end
      if (pc_we) begin
        pop_cmp(K_RUN, int'(pc_wdata), 0, "R5");
        check(run_start, "R5", "run pulse with pc load", int'(run_start), 1);
      end
      if (oper_req && oper_done) pop_cmp(K_OPR, int'(oper_field), 0, "R6");
    end
  end

  task automatic pop_cmp(kind_e k, int addr, int data, string req);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, req, "unexpected event", int'(k), -1);
      return;
    end
    e = q.pop_front();
    check(e.kind == k, req, "event kind", int'(k), int'(e.kind));
    check(e.addr == addr, req, "address/field", addr, e.addr);
    check(e.data == data, req, "data", data, e.data);
  endtask

  task automatic press(int hold);
    step_btn = 1'b1;
    repeat (hold) @(negedge clk);
    step_btn = 1'b0;
  endtask

  // driver: sets switches, predicts, presses, scrambles (R10), waits idle
  task automatic run_op(logic [17:0] ins, logic [17:0] dat, int hold);
    exp_t e;
    instr_sw = ins; data_sw = dat;
    e.addr = int'(ins[15:0]);
    e.data = 0;
    case (ins[17:16])
      2'b00: begin e.kind = K_WR; e.data = int'(dat); end
      2'b01: begin e.kind = K_ADD; e.data = int'(bench_add(acc_q, mem[ins[5:0]])); end
      2'b10: e.kind = K_RUN;
      default: e.kind = K_OPR;
    endcase
    q.push_back(e);
    press(hold);
    instr_sw = ~ins; data_sw = ~dat;
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    oper_lat = 2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(!test_mode && !core_hold && !busy, "R1", "idle after reset", int'({test_mode, core_hold, busy}), 0);
    check(!mem_req && !acc_we && !pc_we && !run_start && !oper_req, "R1", "no outputs after reset",
          int'({mem_req, acc_we, pc_we, run_start, oper_req}), 0);

    // R7 step outside test mode ignored
    instr_sw = {2'b00, 16'o7}; data_sw = 18'o123;
    press(4);
    repeat (12) @(negedge clk);
    check(!busy && mem[7] == init_word(7), "R7", "step outside test mode", int'(mem[7]), int'(init_word(7)));

    // R2 enter test mode
    mode_sw = 1'b1;
    repeat (5) @(negedge clk);
    check(test_mode && core_hold, "R2", "test mode entered", int'({test_mode, core_hold}), 3);

    // R3 deposit with R10 scramble
    run_op({2'b00, 16'o12}, 18'o707070, 4);
    check(mem[10] == 18'o707070, "R3", "deposited word", int'(mem[10]), 18'o707070);

    // R4 add with end-around carry: 5 + 777776 -> 4
    run_op({2'b01, 16'o3}, 18'o0, 4);
    check(acc_q == 18'o4, "R4", "end-around sum", int'(acc_q), 18'o4);

    // R4 add without carry, R8 long press gives one op
    run_op({2'b01, 16'o2}, 18'o0, 30);
    check(acc_q == 18'o2006, "R8", "single add on long press", int'(acc_q), 18'o2006);

    // R6 operate, R7 step while busy ignored
    oper_lat = 20;
    fork
      run_op({2'b11, 16'o600}, 18'o0, 4);
      begin
        repeat (10) @(negedge clk);
        instr_sw = {2'b00, 16'o7};
        press(4);
      end
    join
    repeat (12) @(negedge clk);
    check(mem[7] == init_word(7), "R7", "step while busy", int'(mem[7]), int'(init_word(7)));

    // R5 leave test mode and run
    run_op({2'b10, 16'o41}, 18'o0, 4);
    check(!test_mode && !core_hold, "R5", "left test mode", int'({test_mode, core_hold}), 0);
    check(pc_q == 16'o41, "R5", "program counter", int'(pc_q), 18'o41);

    // R7 after leaving, steps ignored
    instr_sw = {2'b00, 16'o14}; data_sw = 18'o1;
    press(4);
    repeat (12) @(negedge clk);
    check(mem[12] == init_word(12), "R7", "step after run", int'(mem[12]), int'(init_word(12)));

    // R2 re-enter by a new switch edge
    mode_sw = 1'b0;
    repeat (5) @(negedge clk);
    mode_sw = 1'b1;
    repeat (5) @(negedge clk);
    check(test_mode, "R2", "re-entered test mode", int'(test_mode), 1);
    run_op({2'b00, 16'o5}, 18'o252525, 4);
    check(mem[5] == 18'o252525, "R3", "deposit after re-entry", int'(mem[5]), 18'o252525);

    check(q.size() == 0, "R7", "all predicted events seen", q.size(), 0);
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule